// File: doc/BRIEF.md
# Loop Supervision and Automatic Ring Trip Controller

This block turns a raw loop-current comparator bit from a subscriber line into a clean switch-hook indication, and drives the ringing relay on the controller's request. The raw bit is synchronised and then sampled on a millisecond time base. A hook change reaches the output only after it has held for a set number of milliseconds, in both directions. Dial-pulse make and break intervals therefore reach the output whenever ringing is not applied.

While ringing is applied, the normal hook filter is frozen. A separate, longer filter watches for sustained loop current. When that current lasts the full ring-trip window, the block drops the ringing relay on its own, reports off-hook and latches the trip. The latch holds the relay off until the controller withdraws its ringing request and asserts it again. Each time ringing is removed, a blanking interval follows in which hook samples are discarded, so that switching transients cannot reach the output.

Top module: `hook_supervisor`

## Requirements
- R1: Out of reset `hook_n`=1 (on-hook), `led_n`=1, `ring_relay_n`=1 (relay released) and `tripped`=0. `hook_n` is active low (0 means off-hook) and `led_n` always carries the same value as `hook_n`.
- R2: `loop_raw` (1 = loop current present, meaning off-hook) passes through two flip-flops and is then sampled once per millisecond tick. A tick occurs every `TICK_DIV` clock cycles.
- R3: An on-hook to off-hook change reaches `hook_n` only after `DEB_MS` consecutive tick samples show off-hook. A loop pulse of at most (`DEB_MS`-1)·`TICK_DIV` cycles is ignored, and one of at least `DEB_MS`·`TICK_DIV` cycles is accepted.
- R4: An off-hook to on-hook change is filtered by the same rule, with the same pulse-width bounds.
- R5: When ringing is inactive, a train of dial-pulse breaks and makes, each longer than the debounce window, is followed by `hook_n`.
- R6: While `ring_req`=1 and no trip is latched, `ring_relay_n` is 0 from the cycle after the request. Otherwise it is 1 from the cycle after.
- R7: While ringing is applied, `hook_n` holds its value. A loop-current burst covering fewer than `TRIP_MS` ticks neither trips the ringing nor changes `hook_n`.
- R8: Loop current sustained for `TRIP_MS` consecutive ticks during ringing produces all three of the following in the same cycle: `ring_relay_n` goes to 1, `tripped` goes to 1, and `hook_n` goes to 0.
- R9: After a trip, the relay stays released while `ring_req` stays high. `tripped` clears the cycle after `ring_req` falls, and a new request drives the relay again.
- R10: For `BLANK_MS` ticks after ringing is removed, hook samples are ignored. Debouncing restarts only after that interval.
- R11: `hook_n` changes only in the cycle after a millisecond tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_raw | input | 1 | Raw loop-current comparator bit, asynchronous, 1 = current flowing |
| ring_req | input | 1 | Ringing request from the line controller |
| hook_n | output | 1 | Debounced switch-hook state, 0 = off-hook |
| led_n | output | 1 | LED drive, same polarity as `hook_n` |
| ring_relay_n | output | 1 | Ringing relay drive, 0 = relay energised |
| tripped | output | 1 | Ring trip latched for the current request |

## Verification
The bench builds the block with a 4-cycle tick, a 3 ms debounce, a 5 ms trip window and a 4 ms blank. With these values every timing window spans only a few dozen cycles. Loop pulse widths are swept cycle by cycle through the whole region around both debounce bounds, in both hook directions. The sweep confirms that pulses at or below the lower bound are rejected and pulses at or above the upper bound are accepted. The short windows also make it possible to bracket the trip latency and the post-ringing blank between computed earliest and latest cycles, and to exercise re-ringing after a trip.

// File: rtl/hook_sup_pkg.sv
package hook_sup_pkg;

  // bits needed to hold counts 0 .. n-1
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // true when one more step reaches the limit
  function automatic logic last_step(int unsigned cnt, int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] sh;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign q = sh[N-1];
endmodule

// File: rtl/hs_tick.sv
module hs_tick
  import hook_sup_pkg::*;
#(
  parameter int unsigned DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = cnt_bits(DIV);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
      assign tick = last_step(32'(cnt), DIV);
    end
  endgenerate
endmodule

// File: rtl/hs_debounce.sv
module hs_debounce
  import hook_sup_pkg::*;
#(
  parameter int unsigned DEB_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample,     // 1 = off-hook reading
  input  logic hold,       // freeze filtering
  input  logic force_off,  // confirmed trip: go off-hook now
  output logic off_hook
);
  localparam int unsigned W = cnt_bits(DEB_MS);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_hook <= 1'b0;
      cnt      <= '0;
    end else if (force_off) begin
      off_hook <= 1'b1;
      cnt      <= '0;
    end else if (hold) begin
      cnt <= '0;
    end else if (tick) begin
      if (sample == off_hook) begin
        cnt <= '0;
      end else if (last_step(32'(cnt), DEB_MS)) begin
        off_hook <= sample;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_ring_ctrl.sv
module hs_ring_ctrl
  import hook_sup_pkg::*;
#(
  parameter int unsigned TRIP_MS  = 100,
  parameter int unsigned BLANK_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample,
  input  logic ring_req,
  output logic ring_on,
  output logic tripped,
  output logic trip_evt,
  output logic blanking
);
  localparam int unsigned TW = cnt_bits(TRIP_MS);
  logic [TW-1:0] tcnt;
  logic          ring_on_nx;

  assign trip_evt   = ring_on && tick && sample && last_step(32'(tcnt), TRIP_MS);
  assign ring_on_nx = ring_req && !tripped && !trip_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_on <= 1'b0;
      tripped <= 1'b0;
      tcnt    <= '0;
    end else begin
      ring_on <= ring_on_nx;
      if (!ring_req)     tripped <= 1'b0;
      else if (trip_evt) tripped <= 1'b1;
      if (!ring_on || trip_evt)    tcnt <= '0;
      else if (tick && !sample)    tcnt <= '0;
      else if (tick)               tcnt <= tcnt + 1'b1;
    end
  end

  generate
    if (BLANK_MS == 0) begin : g_noblank
      assign blanking = 1'b0;
    end else begin : g_blank
      localparam int unsigned BW = cnt_bits(BLANK_MS + 1);
      logic [BW-1:0] bcnt;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                    bcnt <= '0;
        else if (ring_on && !ring_on_nx) bcnt <= BW'(BLANK_MS);
        else if (tick && bcnt != '0)   bcnt <= bcnt - 1'b1;
      assign blanking = (bcnt != '0);
    end
  endgenerate
endmodule

// File: rtl/hook_supervisor.sv
module hook_supervisor #(
  parameter int unsigned TICK_DIV = 125000,
  parameter int unsigned DEB_MS   = 20,
  parameter int unsigned TRIP_MS  = 100,
  parameter int unsigned BLANK_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_raw,
  input  logic ring_req,
  output logic hook_n,
  output logic led_n,
  output logic ring_relay_n,
  output logic tripped
);
  // named internal events, visible to the checker
  logic tick_w;
  logic loop_s_w;
  logic ring_on_w;
  logic trip_evt_w;
  logic blank_w;
  logic hold_w;
  logic off_hook_w;

  hs_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(loop_raw), .q(loop_s_w)
  );

  hs_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  hs_ring_ctrl #(.TRIP_MS(TRIP_MS), .BLANK_MS(BLANK_MS)) u_ring (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .sample(loop_s_w),
    .ring_req(ring_req), .ring_on(ring_on_w), .tripped(tripped),
    .trip_evt(trip_evt_w), .blanking(blank_w)
  );

  assign hold_w = ring_on_w || blank_w;

  hs_debounce #(.DEB_MS(DEB_MS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .sample(loop_s_w),
    .hold(hold_w), .force_off(trip_evt_w), .off_hook(off_hook_w)
  );

  assign hook_n       = !off_hook_w;
  assign led_n        = !off_hook_w;
  assign ring_relay_n = !ring_on_w;
endmodule

// File: rtl/hook_supervisor_chk.sv
module hook_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic ring_req,
  input logic hook_n,
  input logic led_n,
  input logic ring_relay_n,
  input logic tripped,
  input logic tick_w,
  input logic ring_on_w,
  input logic trip_evt_w
);
  assert_led_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
    led_n == hook_n);

  assert_no_relay_after_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> ring_relay_n);

  assert_trip_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_req |=> !tripped);

  assert_relay_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_req |=> ring_relay_n);

  assert_hook_frozen_ringing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_on_w && !trip_evt_w) |=> $stable(hook_n));

  assert_trip_effects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt_w |=> (!hook_n && ring_relay_n && tripped));

  assert_hook_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hook_n) |-> $past(tick_w));
endmodule

bind hook_supervisor hook_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .hook_n(hook_n),
  .led_n(led_n), .ring_relay_n(ring_relay_n), .tripped(tripped),
  .tick_w(tick_w), .ring_on_w(ring_on_w), .trip_evt_w(trip_evt_w)
);

// File: tb/hook_supervisor_test.sv
module hook_supervisor_test;
  localparam int DIV = 4, DEB = 3, TRIP = 5, BLANK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_raw = 1'b0;
  logic ring_req = 1'b0;
  logic hook_n, led_n, ring_relay_n, tripped;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = !clk;

  hook_supervisor #(.TICK_DIV(DIV), .DEB_MS(DEB), .TRIP_MS(TRIP), .BLANK_MS(BLANK)) uut (
    .clk(clk), .rst_n(rst_n), .loop_raw(loop_raw), .ring_req(ring_req),
    .hook_n(hook_n), .led_n(led_n), .ring_relay_n(ring_relay_n), .tripped(tripped)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // hold loop at lvl for w cycles, return to !lvl, report whether hook moved
  task automatic pulse(logic lvl, int w, output bit moved);
    logic start;
    start = hook_n;
    moved = 0;
    loop_raw = lvl;
    for (int i = 0; i < w; i++) begin
      cyc(1);
      if (hook_n !== start) moved = 1;
    end
    loop_raw = !lvl;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (hook_n !== start) moved = 1;
    end
  endtask

  initial begin
    bit moved;
    cyc(3);
    chk("R1 reset hook_n", hook_n, 1'b1);
    chk("R1 reset led_n", led_n, 1'b1);
    chk("R1 reset relay", ring_relay_n, 1'b1);
    chk("R1 reset tripped", tripped, 1'b0);
    rst_n = 1'b1;
    cyc(5);

    // R2/R3 latency: earliest flip observed at 11, latest at 14
    loop_raw = 1'b1;
    cyc(10);
    chk("R3 latency early", hook_n, 1'b1);
    cyc(5);
    chk("R3 latency late", hook_n, 1'b0);
    chk("R1 led follows", led_n, 1'b0);
    loop_raw = 1'b0;
    cyc(40);
    chk("R4 back on-hook", hook_n, 1'b1);

    // R3 sweep: off-hook pulses of w cycles from on-hook
    for (int w = 1; w <= 16; w++) begin
      pulse(1'b1, w, moved);
      if (w <= (DEB - 1) * DIV) chk("R3 short pulse rejected", moved, 1'b0);
      else if (w >= DEB * DIV)  chk("R3 long pulse accepted", moved, 1'b1);
    end

    // R4 sweep: on-hook breaks from off-hook
    loop_raw = 1'b1;
    cyc(30);
    chk("R4 setup off-hook", hook_n, 1'b0);
    for (int w = 1; w <= 16; w++) begin
      pulse(1'b0, w, moved);
      if (w <= (DEB - 1) * DIV) chk("R4 short break rejected", moved, 1'b0);
      else if (w >= DEB * DIV)  chk("R4 long break accepted", moved, 1'b1);
    end

    // R5 dial pulse train: breaks and makes of 24 cycles
    for (int p = 0; p < 4; p++) begin
      loop_raw = 1'b0;
      cyc(20);
      chk("R5 dial break seen", hook_n, 1'b1);
      cyc(4);
      loop_raw = 1'b1;
      cyc(20);
      chk("R5 dial make seen", hook_n, 1'b0);
      cyc(4);
    end
    loop_raw = 1'b0;
    cyc(40);

    // R6 ringing on
    ring_req = 1'b1;
    cyc(1);
    chk("R6 relay driven", ring_relay_n, 1'b0);
    // R7 burst of 15 cycles covers at most 4 ticks
    cyc(10);
    loop_raw = 1'b1;
    cyc(15);
    loop_raw = 1'b0;
    cyc(1);
    chk("R7 hook frozen in burst", hook_n, 1'b1);
    cyc(30);
    chk("R7 no trip on burst", tripped, 1'b0);
    chk("R7 relay still on", ring_relay_n, 1'b0);
    chk("R7 hook still on-hook", hook_n, 1'b1);

    // R8 sustained: trip observed between 19 and 22
    loop_raw = 1'b1;
    cyc(18);
    chk("R8 relay before window", ring_relay_n, 1'b0);
    chk("R8 hook before window", hook_n, 1'b1);
    cyc(5);
    chk("R8 relay released", ring_relay_n, 1'b1);
    chk("R8 tripped set", tripped, 1'b1);
    chk("R8 hook off", hook_n, 1'b0);
    cyc(30);
    chk("R9 relay held off", ring_relay_n, 1'b1);
    chk("R9 latch held", tripped, 1'b1);
    ring_req = 1'b0;
    cyc(1);
    chk("R9 latch cleared", tripped, 1'b0);
    ring_req = 1'b1;
    cyc(1);
    chk("R9 re-ring drives relay", ring_relay_n, 1'b0);
    ring_req = 1'b0;
    cyc(1);
    chk("R6 relay released on drop", ring_relay_n, 1'b1);
    loop_raw = 1'b0;
    cyc(60);
    chk("R4 on-hook after ringing", hook_n, 1'b1);

    // R10 blanking: ring, drop, go off-hook at once
    ring_req = 1'b1;
    cyc(20);
    ring_req = 1'b0;
    loop_raw = 1'b1;
    cyc(20);
    chk("R10 blank hides off-hook", hook_n, 1'b1);
    cyc(10);
    chk("R10 off-hook after blank", hook_n, 1'b0);
    loop_raw = 1'b0;
    cyc(40);
    chk("R10 settle on-hook", hook_n, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule